// File: doc/BRIEF.md
# Block Parity Decimator for Raw Random Bits

This block reduces the redundancy of a raw random bit stream by folding every group of `p` accepted input bits into a single output bit. A single toggle flip-flop absorbs each accepted bit. The block has two modes, and they differ only in whether that flip-flop is emptied when a group completes.

In group mode the flip-flop is cleared after every group, so each output bit is the parity of exactly one group. In running mode the flip-flop is never cleared at a group boundary, so each output bit is the parity of everything seen since the last restart, sampled once per group. Both modes divide the bit rate by `p`. `p` can be set from 2 to 6. Odd values keep the output balanced when the source is symmetric. Setting 5 is the usual choice, for example 1 Mbit/s out of a 5 MHz source.

A source of raw bits drives `rawBit` qualified by `rawValid`. Results are taken from `outBit` whenever `outValid` pulses.

Top module: `parity_decimator`

## Requirements
- R1: A synchronous active-high `rst` clears `outBit` to 0, `outValid` to 0, the toggle flip-flop and the group position; the next accepted bit after reset is the first bit of a group.
- R2: With `modeSkip` = 0 (group mode), each `outBit` equals the XOR of the `p` bits of the group just completed, independent of earlier groups.
- R3: With `modeSkip` = 1 (running mode), the first output after reset or restart is the parity of its group; every later output equals the previous `outBit` XOR the parity of the newest group.
- R4: `outValid` is a registered single-cycle pulse, high in the cycle after the clock edge that accepts the p-th bit of a group, so exactly one output follows every `p` accepted bits.
- R5: A clock edge with `rawValid` = 0 accepts nothing: `rawBit` is ignored and the group position does not advance.
- R6: `blockLen` values 2 to 6 set `p` directly; values 0 and 1 act as 2 and value 7 acts as 6.
- R7: When the effective `p` or `modeSkip` differs from its value on the previous edge, the block restarts: the toggle flip-flop is emptied, and a bit accepted on that edge is the first bit of a new group (in running mode the next output is that group's own parity).
- R8: `outBit` holds its value in every cycle that `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rawBit | input | 1 | Raw random bit |
| rawValid | input | 1 | Qualifies `rawBit` for acceptance on this edge |
| modeSkip | input | 1 | 0 selects group mode, 1 selects running mode |
| blockLen | input | 3 | Requested group length p, clamped to 2..6 |
| outBit | output | 1 | Decimated output bit |
| outValid | output | 1 | One-cycle pulse marking a new `outBit` |

## Verification
Every result comes from a register one edge away from its stimulus. The p-th accepted bit of a group shows up on `outValid`/`outBit` after exactly one rising edge, and a reset shows up after exactly one edge as well. The bench drives inputs on the falling edge, lets one rising edge pass and samples on the next falling edge. Each sample therefore falls in the single cycle where the pulse is due. `outValid` must be low after every non-final bit and on idle cycles, and `outBit` is re-read after idle cycles to confirm that it has held.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic accept;    // a raw bit is taken on this edge
    logic blockEnd;  // the accepted bit closes a group
    logic restart;   // configuration changed: start afresh
    logic skipMode;  // running (1) or group (0) parity
  } pdecStrobe_t;

endpackage

// File: rtl/pdec_len_clamp.sv
module pdec_len_clamp #(
  parameter int LEN_W = 3,
  parameter int P_MIN = 2,
  parameter int P_MAX = 6
) (
  input  logic [LEN_W-1:0] reqLen,
  output logic [LEN_W-1:0] effLen
);

  localparam logic [LEN_W-1:0] LO = LEN_W'(P_MIN);
  localparam logic [LEN_W-1:0] HI = LEN_W'(P_MAX);

  always_comb begin
    if (reqLen < LO)      effLen = LO;
    else if (reqLen > HI) effLen = HI;
    else                  effLen = reqLen;
  end

endmodule

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
  import pdec_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int P_MIN = 2,
  parameter int P_MAX = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rawValid,
  input  logic             modeSkip,
  input  logic [LEN_W-1:0] blockLen,
  output pdecStrobe_t      strb
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] pLen;
  logic [LEN_W-1:0] prevLen;
  logic             prevMode;
  logic [LEN_W-1:0] curPos;
  logic [LEN_W-1:0] basePos;
  logic             cfgChange;
  logic             lastBit;

  pdec_len_clamp #(
    .LEN_W(LEN_W),
    .P_MIN(P_MIN),
    .P_MAX(P_MAX)
  ) u_clamp (
    .reqLen(blockLen),
    .effLen(pLen)
  );

  assign cfgChange = (pLen != prevLen) || (modeSkip != prevMode);
  assign basePos   = cfgChange ? '0 : curPos;
  assign lastBit   = (basePos == (pLen - ONE));

  always_comb begin
    strb.accept   = rawValid;
    strb.blockEnd = rawValid && lastBit;
    strb.restart  = cfgChange;
    strb.skipMode = modeSkip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curPos   <= '0;
      prevLen  <= LEN_W'(P_MIN);
      prevMode <= 1'b0;
    end else begin
      prevLen  <= pLen;
      prevMode <= modeSkip;
      if (rawValid) curPos <= lastBit ? '0 : basePos + ONE;
      else          curPos <= basePos;
    end
  end

  // R6: outside a restart cycle the position stays inside the group
  a_r6_pos_in_block: assert property (@(posedge clk) disable iff (rst)
    !cfgChange |-> (curPos < pLen));

  // R7: a restart without a bit leaves the position at the group start
  a_r7_restart_pos: assert property (@(posedge clk) disable iff (rst)
    (cfgChange && !rawValid) |=> (curPos == '0));

  // R5: an idle edge does not move the position
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!rawValid && !cfgChange) |=> $stable(curPos));

endmodule

// File: rtl/pdec_datapath.sv
module pdec_datapath
  import pdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rawBit,
  input  pdecStrobe_t strb,
  output logic        outBit,
  output logic        outValid
);

  logic toggleQ;
  logic baseAcc;
  logic nextParity;

  assign baseAcc    = strb.restart ? 1'b0 : toggleQ;
  assign nextParity = baseAcc ^ rawBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      toggleQ  <= 1'b0;
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      if (strb.accept) begin
        if (strb.blockEnd) begin
          outBit   <= nextParity;
          outValid <= 1'b1;
          toggleQ  <= strb.skipMode ? nextParity : 1'b0;
        end else begin
          toggleQ  <= nextParity;
        end
      end else begin
        toggleQ <= baseAcc;
      end
    end
  end

  // R1: reset empties the outputs and the toggle flip-flop
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!outValid && !outBit && !toggleQ));

  // R4: pulses never run back to back since p is at least two
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R2: group mode leaves the flip-flop empty after a group closes
  a_r2_group_cleared: assert property (@(posedge clk) disable iff (rst)
    (strb.blockEnd && !strb.skipMode) |=> !toggleQ);

  // R3: running mode keeps the flip-flop equal to the last output
  a_r3_running_tracks: assert property (@(posedge clk) disable iff (rst)
    (strb.blockEnd && strb.skipMode) |=> (toggleQ == outBit));

  // R8: output holds unless a group has just closed
  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.blockEnd |=> $stable(outBit));

endmodule

// File: rtl/parity_decimator.sv
module parity_decimator
  import pdec_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int P_MIN = 2,
  parameter int P_MAX = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rawBit,
  input  logic             rawValid,
  input  logic             modeSkip,
  input  logic [LEN_W-1:0] blockLen,
  output logic             outBit,
  output logic             outValid
);

  pdecStrobe_t strb;

  pdec_ctrl #(
    .LEN_W(LEN_W),
    .P_MIN(P_MIN),
    .P_MAX(P_MAX)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .rawValid(rawValid),
    .modeSkip(modeSkip),
    .blockLen(blockLen),
    .strb(strb)
  );

  pdec_datapath u_dp (
    .clk(clk),
    .rst(rst),
    .rawBit(rawBit),
    .strb(strb),
    .outBit(outBit),
    .outValid(outValid)
  );

endmodule

// File: tb/sim_parity_decimator.sv
module sim_parity_decimator;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rawBit = 1'b0;
  logic       rawValid = 1'b0;
  logic       modeSkip = 1'b0;
  logic [2:0] blockLen = 3'd2;
  logic       outBit;
  logic       outValid;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  parity_decimator u0 (
    .clk(clk), .rst(rst), .rawBit(rawBit), .rawValid(rawValid),
    .modeSkip(modeSkip), .blockLen(blockLen),
    .outBit(outBit), .outValid(outValid)
  );

  // {mode, len, nbits, bits (LSB sent first)}
  localparam logic [32:0] VECS [0:7] = '{
    {1'b0, 3'd2, 5'd8,  24'h0000A5},
    {1'b0, 3'd3, 5'd12, 24'h0005C3},
    {1'b0, 3'd5, 5'd20, 24'h0B39E1},
    {1'b0, 3'd6, 5'd24, 24'h8F31C7},
    {1'b1, 3'd2, 5'd8,  24'h00006D},
    {1'b1, 3'd3, 5'd12, 24'h0009A6},
    {1'b1, 3'd5, 5'd20, 24'h03C5A9},
    {1'b1, 3'd4, 5'd16, 24'h00E17B}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // drive on falling edge, one rising edge, sample on next falling edge
  task automatic sendBit(input logic b);
    rawValid = 1'b1;
    rawBit   = b;
    @(posedge clk);
    @(negedge clk);
    rawValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rawValid = 1'b0;
      rawBit   = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    rawValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    check("R1 outValid after reset", outValid, 1'b0);
    check("R1 outBit after reset", outBit, 1'b0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic       mode;
      logic [2:0] len;
      logic [4:0] nb;
      logic [23:0] bits;
      logic blockPar;
      logic runPar;
      int pos;
      {mode, len, nb, bits} = VECS[v];
      modeSkip = mode;
      blockLen = len;
      doReset();
      idle(2);
      blockPar = 1'b0;
      runPar   = 1'b0;
      pos      = 0;
      for (int i = 0; i < int'(nb); i++) begin
        sendBit(bits[i]);
        blockPar ^= bits[i];
        pos++;
        if (pos == int'(len)) begin
          runPar ^= blockPar;
          check(mode ? "R3 running pulse" : "R2 group pulse", outValid, 1'b1);
          check(mode ? "R3 running value" : "R2 group value", outBit,
                mode ? runPar : blockPar);
          blockPar = 1'b0;
          pos = 0;
        end else begin
          check("R4 no pulse mid-group", outValid, 1'b0);
        end
      end
    end

    // R1: reset mid-group discards partial state
    modeSkip = 1'b0; blockLen = 3'd3;
    doReset(); idle(1);
    sendBit(1'b1); sendBit(1'b0);
    doReset(); idle(1);
    sendBit(1'b0); sendBit(1'b0);
    check("R1 no early pulse after reset", outValid, 1'b0);
    sendBit(1'b0);
    check("R1 fresh group pulse", outValid, 1'b1);
    check("R1 fresh group value", outBit, 1'b0);

    // R5 and R8: idle edges ignored, output holds
    sendBit(1'b1);
    idle(3);
    check("R5 idle no pulse", outValid, 1'b0);
    check("R8 outBit held", outBit, 1'b0);
    sendBit(1'b0);
    check("R5 position not advanced", outValid, 1'b0);
    sendBit(1'b0);
    check("R5 pulse after third valid bit", outValid, 1'b1);
    check("R5 idle rawBit ignored", outBit, 1'b1);
    idle(2);
    check("R8 outBit holds after pulse", outBit, 1'b1);
    check("R4 pulse lasts one cycle", outValid, 1'b0);

    // R6: clamping
    blockLen = 3'd0; doReset(); idle(1);
    sendBit(1'b1);
    check("R6 len 0 acts as 2 (no pulse)", outValid, 1'b0);
    sendBit(1'b0);
    check("R6 len 0 acts as 2 (pulse)", outValid, 1'b1);
    check("R6 len 0 value", outBit, 1'b1);
    blockLen = 3'd1; idle(1);
    sendBit(1'b1); sendBit(1'b1);
    check("R6 len 1 acts as 2", outValid, 1'b1);
    check("R6 len 1 value", outBit, 1'b0);
    blockLen = 3'd7; doReset(); idle(1);
    for (int i = 0; i < 5; i++) begin
      sendBit(1'b1);
      check("R6 len 7 no early pulse", outValid, 1'b0);
    end
    sendBit(1'b0);
    check("R6 len 7 acts as 6", outValid, 1'b1);
    check("R6 len 7 value", outBit, 1'b1);

    // R7: length change mid-group, bit on change edge starts new group
    modeSkip = 1'b0; blockLen = 3'd4; doReset(); idle(1);
    sendBit(1'b1); sendBit(1'b0);
    blockLen = 3'd3;
    sendBit(1'b0);
    sendBit(1'b0);
    check("R7 no pulse at old boundary", outValid, 1'b0);
    sendBit(1'b0);
    check("R7 new group pulse", outValid, 1'b1);
    check("R7 new group value", outBit, 1'b0);

    // R7: mode change restarts running parity
    modeSkip = 1'b1; blockLen = 3'd2; doReset(); idle(1);
    sendBit(1'b1); sendBit(1'b0);
    check("R3 first running output", outBit, 1'b1);
    sendBit(1'b1); sendBit(1'b1);
    check("R3 running keeps previous", outBit, 1'b1);
    sendBit(1'b1);
    modeSkip = 1'b0;
    sendBit(1'b0); sendBit(1'b1);
    check("R7 mode change to group pulse", outValid, 1'b1);
    check("R7 mode change to group value", outBit, 1'b1);
    modeSkip = 1'b1;
    sendBit(1'b0); sendBit(1'b1);
    check("R7 running restarted value", outBit, 1'b1);

    summary();
    $finish;
  end

endmodule